// File: doc/BRIEF.md
# Byte-Lane Steering Unit for a 16-bit Data Bus

This unit sits between a byte-addressed execution core and a 16-bit external data bus made of two 8-bit lanes. The core posts one request at a time (read or write, byte or word, with a byte address), and the unit turns it into one or two bus cycles. Each bus cycle carries the full byte address, whose bit 0 enables the low lane when it is 0, and an active-low high-lane enable. Write bytes are placed on the lane that matches their address. Read bytes are collected from the lane they arrive on and returned right-justified.

Words are little-endian. A word at an even address moves in one bus cycle over both lanes. A word at an odd address is split. The first cycle, at the given address, carries the word's low byte on the high lane. The second cycle, at the next address, carries the word's high byte on the low lane. After the last bus cycle of an access the unit pulses `done` for one clock. New requests are ignored until the unit is idle again.

Each bus cycle lasts exactly one clock. `bus_cyc` marks it, and read data on `bus_rdata` is sampled at the end of that clock.

Top module: `bytelane_bridge`

## Requirements
- R1: A byte access at an even address is one bus cycle with `bus_addr` equal to the request address, so bit 0 is 0, and `bus_hi_n` = 1. A write places the byte on `bus_wdata[7:0]`.
- R2: A byte access at an odd address is one bus cycle with `bus_addr` bit 0 = 1 and `bus_hi_n` = 0. A write places the byte on `bus_wdata[15:8]`. Any bus cycle at an odd address has `bus_hi_n` = 0.
- R3: A byte read returns the addressed byte in `rdata[7:0]` with `rdata[15:8]` = 0. For an odd address that byte is taken from `bus_rdata[15:8]`, and for an even address from `bus_rdata[7:0]`.
- R4: A word access at an even address is exactly one bus cycle with bit 0 = 0 and `bus_hi_n` = 0. A write drives `req_wdata` unchanged on all 16 bits.
- R5: A word access at an odd address A is exactly two back-to-back bus cycles. The first is at A with `bus_hi_n` = 0 and carries data bits 7:0 on lane bits 15:8. The second is at A+1, which wraps at the address width, with `bus_hi_n` = 1 and carries data bits 15:8 on lane bits 7:0.
- R6: Word data is little-endian. A word read at address A returns the byte at A in `rdata[7:0]` and the byte at A+1 in `rdata[15:8]`, whether A is even or odd.
- R7: `done` is high for exactly one clock, in the clock right after the last bus cycle of each access. `rdata` is valid while `done` is high.
- R8: While `busy` is high, `req_valid` is ignored. It starts no bus cycle and changes no memory location, and a new request is accepted only once `busy` is low.
- R9: In reset, and in the first clock after reset is released, `done`, `busy` and `bus_cyc` are 0. This holds even when reset arrives in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 16 | Write data, right-justified for bytes |
| busy | output | 1 | Access in progress, requests ignored |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read data, right-justified for bytes |
| bus_cyc | output | 1 | A bus cycle is in progress this clock |
| bus_we | output | 1 | Bus cycle direction, 1 = write |
| bus_addr | output | ADDR_W | Bus byte address, bit 0 enables the low lane when 0 |
| bus_hi_n | output | 1 | Active-low high-lane enable |
| bus_wdata | output | 16 | Steered write data, unused lane driven 0 |
| bus_rdata | input | 16 | Read data from the bus, sampled at the end of a read cycle |

## Verification
The bench goes after the odd-address word in both directions, including one that wraps from the top of the bench memory to address 0. A design that forgot to split it would issue one cycle with bit 0 set and lose a byte, and one that swapped the byte order would return the two bytes reversed. Odd-byte reads are checked for the shift down to bits 7:0. A design that skipped that shift would return the byte in the upper half. A request held high through a busy access must leave no trace: a design that queued or took it would write a byte that the later read-back exposes. Reset in the middle of a split access must stop bus activity at once.

// File: rtl/bls_pkg.sv
package bls_pkg;

    localparam int LANE_W  = 8;
    localparam int LANES   = 2;
    localparam int BUS_W   = LANE_W * LANES;

    typedef enum logic [2:0] {
        K_BYTE_LO  = 3'd0,
        K_BYTE_HI  = 3'd1,
        K_WORD     = 3'd2,
        K_SPLIT_A  = 3'd3,
        K_SPLIT_B  = 3'd4
    } xfer_kind_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CYC1 = 2'd1,
        S_CYC2 = 2'd2,
        S_FIN  = 2'd3
    } seq_state_t;

    // Kind of the first bus cycle of an access.
    function automatic xfer_kind_t first_kind(input logic word, input logic a0);
        if (word)
            return a0 ? K_SPLIT_A : K_WORD;
        return a0 ? K_BYTE_HI : K_BYTE_LO;
    endfunction

    // Active-low high-lane enable for a cycle kind.
    function automatic logic kind_hi_n(input xfer_kind_t k);
        case (k)
            K_BYTE_HI, K_WORD, K_SPLIT_A: return 1'b0;
            default:                      return 1'b1;
        endcase
    endfunction

    // Place core write data onto bus lanes.
    function automatic logic [BUS_W-1:0] steer_wr(input xfer_kind_t k,
                                                  input logic [BUS_W-1:0] d);
        case (k)
            K_BYTE_LO: return {{LANE_W{1'b0}}, d[LANE_W-1:0]};
            K_BYTE_HI: return {d[LANE_W-1:0], {LANE_W{1'b0}}};
            K_WORD:    return d;
            K_SPLIT_A: return {d[LANE_W-1:0], {LANE_W{1'b0}}};
            K_SPLIT_B: return {{LANE_W{1'b0}}, d[BUS_W-1:LANE_W]};
            default:   return '0;
        endcase
    endfunction

    // Fold one bus read into the accumulated core result.
    function automatic logic [BUS_W-1:0] merge_rd(input xfer_kind_t k,
                                                  input logic [BUS_W-1:0] acc,
                                                  input logic [BUS_W-1:0] bus);
        case (k)
            K_BYTE_LO: return {{LANE_W{1'b0}}, bus[LANE_W-1:0]};
            K_BYTE_HI: return {{LANE_W{1'b0}}, bus[BUS_W-1:LANE_W]};
            K_WORD:    return bus;
            K_SPLIT_A: return {acc[BUS_W-1:LANE_W], bus[BUS_W-1:LANE_W]};
            K_SPLIT_B: return {bus[LANE_W-1:0], acc[LANE_W-1:0]};
            default:   return acc;
        endcase
    endfunction

endpackage

// File: rtl/bls_req_latch.sv
module bls_req_latch
    import bls_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              in_write,
    input  logic              in_word,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BUS_W-1:0]  in_wdata,
    output logic              write_q,
    output logic              word_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BUS_W-1:0]  wdata_q,
    output logic              split
);

    always_ff @(posedge clk) begin
        if (rst) begin
            write_q <= 1'b0;
            word_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            write_q <= in_write;
            word_q  <= in_word;
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    assign split = word_q & addr_q[0];

endmodule

// File: rtl/bls_seq.sv
module bls_seq
    import bls_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic split,
    output logic load,
    output logic cyc,
    output logic second,
    output logic fin,
    output logic busy
);

    seq_state_t state;

    assign load   = (state == S_IDLE) && req_valid;
    assign cyc    = (state == S_CYC1) || (state == S_CYC2);
    assign second = (state == S_CYC2);
    assign fin    = (state == S_FIN);
    assign busy   = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE: if (req_valid) state <= S_CYC1;
                S_CYC1: state <= split ? S_CYC2 : S_FIN;
                S_CYC2: state <= S_FIN;
                default: state <= S_IDLE;
            endcase
        end
    end

    // R5: the second cycle only ever follows a first cycle
    a_r5_second_after_first: assert property (@(posedge clk) disable iff (rst)
        second |-> $past(state) == S_CYC1);

    // R7: completion lasts one clock and returns to idle
    a_r7_fin_then_idle: assert property (@(posedge clk) disable iff (rst)
        fin |=> state == S_IDLE);

endmodule

// File: rtl/bls_lane_drive.sv
module bls_lane_drive
    import bls_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              cyc,
    input  xfer_kind_t        kind,
    input  logic              write_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [BUS_W-1:0]  wdata_q,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_hi_n,
    output logic [BUS_W-1:0]  bus_wdata
);

    logic [BUS_W-1:0]  steered;
    logic [LANES-1:0]  lane_en;
    logic [ADDR_W-1:0] cyc_addr;

    assign steered  = steer_wr(kind, wdata_q);
    assign cyc_addr = (kind == K_SPLIT_B) ? addr_q + ADDR_W'(1) : addr_q;

    assign bus_cyc  = cyc;
    assign bus_we   = cyc & write_q;
    assign bus_addr = cyc ? cyc_addr : '0;
    assign bus_hi_n = cyc ? kind_hi_n(kind) : 1'b1;

    assign lane_en[0] = ~bus_addr[0];
    assign lane_en[1] = ~bus_hi_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bus_wdata[g*LANE_W +: LANE_W] =
            (bus_we && lane_en[g]) ? steered[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/bls_read_asm.sv
module bls_read_asm
    import bls_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             capture,
    input  xfer_kind_t       kind,
    input  logic [BUS_W-1:0] bus_rdata,
    output logic [BUS_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (clear)
            rdata <= '0;
        else if (capture)
            rdata <= merge_rd(kind, rdata, bus_rdata);
    end

endmodule

// File: rtl/bytelane_bridge.sv
module bytelane_bridge
    import bls_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_hi_n,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata
);

    logic              load, cyc, second, split;
    logic              write_q, word_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  wdata_q;
    xfer_kind_t        kind;

    bls_req_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst(rst), .load(load),
        .in_write(req_write), .in_word(req_word),
        .in_addr(req_addr), .in_wdata(req_wdata),
        .write_q(write_q), .word_q(word_q),
        .addr_q(addr_q), .wdata_q(wdata_q), .split(split)
    );

    bls_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .split(split),
        .load(load), .cyc(cyc), .second(second), .fin(done), .busy(busy)
    );

    assign kind = second ? K_SPLIT_B : first_kind(word_q, addr_q[0]);

    bls_lane_drive #(.ADDR_W(ADDR_W)) u_drive (
        .cyc(cyc), .kind(kind), .write_q(write_q),
        .addr_q(addr_q), .wdata_q(wdata_q),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_hi_n(bus_hi_n), .bus_wdata(bus_wdata)
    );

    bls_read_asm u_rd (
        .clk(clk), .rst(rst), .clear(load),
        .capture(cyc & ~write_q), .kind(kind),
        .bus_rdata(bus_rdata), .rdata(rdata)
    );

    // R2: odd bus addresses always enable the high lane
    a_r2_odd_uses_high: assert property (@(posedge clk) disable iff (rst)
        bus_cyc && bus_addr[0] |-> !bus_hi_n);

    // R5: consecutive cycles are the split tail at the next, even address
    a_r5_tail_next_even: assert property (@(posedge clk) disable iff (rst)
        bus_cyc && $past(bus_cyc) |->
            !bus_addr[0] && bus_hi_n && bus_addr == $past(bus_addr) + ADDR_W'(1));

    // R7: done follows a bus cycle and lasts one clock
    a_r7_done_after_cycle: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_cyc));
    a_r7_done_one_clock: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: no bus activity and no completion while idle
    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_cyc && !done);

    // R9: first clock out of reset is quiet
    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bus_cyc && !done && !busy);

endmodule

// File: tb/bytelane_bridge_test.sv
module bytelane_bridge_test;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write, req_word;
    logic [AW-1:0] req_addr;
    logic [15:0]   req_wdata;
    logic          busy, done, bus_cyc, bus_we, bus_hi_n;
    logic [15:0]   rdata, bus_wdata, bus_rdata;
    logic [AW-1:0] bus_addr;

    logic [15:0] mem [16];
    logic [7:0]  ref_b [32];

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    bytelane_bridge #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_cyc(bus_cyc),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_hi_n(bus_hi_n),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Bus-side memory model: lanes written by address bit 0 and high enable
    assign bus_rdata = mem[bus_addr[4:1]];
    always @(posedge clk) begin
        if (bus_cyc && bus_we) begin
            if (!bus_addr[0]) mem[bus_addr[4:1]][7:0]  <= bus_wdata[7:0];
            if (!bus_hi_n)    mem[bus_addr[4:1]][15:8] <= bus_wdata[15:8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {write, word, addr[7:0], data[15:0]}
    localparam logic [25:0] VEC [15] = '{
        {1'b1, 1'b0, 8'h04, 16'h00A5},
        {1'b1, 1'b0, 8'h05, 16'h005C},
        {1'b0, 1'b0, 8'h04, 16'h0000},
        {1'b0, 1'b0, 8'h05, 16'h0000},
        {1'b0, 1'b1, 8'h04, 16'h0000},
        {1'b1, 1'b1, 8'h08, 16'h1234},
        {1'b0, 1'b0, 8'h09, 16'h0000},
        {1'b1, 1'b1, 8'h0B, 16'hBEEF},
        {1'b0, 1'b1, 8'h0B, 16'h0000},
        {1'b0, 1'b1, 8'h0A, 16'h0000},
        {1'b0, 1'b0, 8'h0C, 16'h0000},
        {1'b0, 1'b1, 8'h0C, 16'h0000},
        {1'b1, 1'b1, 8'h1F, 16'h7788},
        {1'b0, 1'b1, 8'h1F, 16'h0000},
        {1'b0, 1'b0, 8'h00, 16'h0000}
    };

    task automatic run_op(input logic wr, input logic wd, input logic [7:0] a,
                          input logic [15:0] d, input logic hold, input logic [7:0] a2);
        int            ncyc = 0;
        int            ndone = 0;
        int            done_i = -1;
        int            last_i = -1;
        logic [AW-1:0] c_addr [2];
        logic          c_hin  [2];
        logic [15:0]   c_wd   [2];
        logic [15:0]   got = '0;
        string         tg, rt;
        int            exp_n;
        logic [4:0]    ia, ib;
        ia = a[4:0];
        ib = ia + 5'd1;
        tg = wd ? (a[0] ? "R5" : "R4") : (a[0] ? "R2" : "R1");
        rt = wd ? "R6" : "R3";
        exp_n = (wd && a[0]) ? 2 : 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd;
        req_addr = AW'(a); req_wdata = d;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bus_cyc) begin
                if (ncyc < 2) begin
                    c_addr[ncyc] = bus_addr; c_hin[ncyc] = bus_hi_n; c_wd[ncyc] = bus_wdata;
                end
                ncyc++;
                last_i = i;
            end
            if (done) begin
                ndone++; done_i = i; got = rdata; req_valid = 1'b0;
            end
            if (i == 0) begin
                if (hold) begin
                    req_write = 1'b1; req_word = 1'b0; req_addr = AW'(a2); req_wdata = ~d;
                end else begin
                    req_valid = 1'b0;
                end
            end
        end
        req_valid = 1'b0;
        chk(tg, ncyc, exp_n);
        chk("R7", ndone, 1);
        chk("R7", done_i, last_i + 1);
        chk(tg, 32'(c_addr[0]), 32'(a));
        chk(tg, c_hin[0], (!wd && !a[0]) ? 1 : 0);
        if (exp_n == 2) begin
            chk("R5", 32'(c_addr[1]), 32'(a) + 1);
            chk("R5", c_hin[1], 1);
        end
        if (wr) begin
            if (!wd && !a[0]) chk("R1", c_wd[0][7:0], d[7:0]);
            if (!wd && a[0])  chk("R2", c_wd[0][15:8], d[7:0]);
            if (wd && !a[0])  chk("R4", c_wd[0], d);
            if (wd && a[0]) begin
                chk("R5", c_wd[0][15:8], d[7:0]);
                chk("R5", c_wd[1][7:0], d[15:8]);
            end
            ref_b[ia] = d[7:0];
            if (wd) ref_b[ib] = d[15:8];
        end else begin
            chk(rt, got, wd ? {ref_b[ib], ref_b[ia]} : {8'h00, ref_b[ia]});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = {8'(8'h81 + 2*i), 8'(8'h40 + 2*i)};
            ref_b[2*i]   = 8'(8'h40 + 2*i);
            ref_b[2*i+1] = 8'(8'h81 + 2*i);
        end
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R9", {done, busy, bus_cyc}, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", {done, busy, bus_cyc}, 3'b000);

        foreach (VEC[k])
            run_op(VEC[k][25], VEC[k][24], VEC[k][23:16], VEC[k][15:0], 1'b0, 8'h00);

        // R8: a request held through a split write must be dropped
        run_op(1'b1, 1'b1, 8'h11, 16'hA1B2, 1'b1, 8'h14);
        run_op(1'b0, 1'b0, 8'h14, 16'h0000, 1'b0, 8'h00);
        chk("R8", mem[5'h14 >> 1][7:0], ref_b[5'h14]);

        // R9: reset in the middle of a split access
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = AW'(8'h07);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", bus_cyc, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R9", {done, busy, bus_cyc}, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", {done, busy, bus_cyc}, 3'b000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule